// File: doc/BRIEF.md
# Stack Pointer Unit with Overflow and Underflow Guard

This block owns the stack pointer of a small word-addressed bytecode machine whose memory holds the program image, a heap region and a stack region. Before execution a loader hands it three size words (heap size, stack size, program length) and a commit strobe. On commit the memory size becomes their sum and the stack pointer is placed one past the last valid address, so the first push lands in the top word of memory. The lowest address the stack may ever use is the memory size minus the stack size.

At run time the instruction sequencer issues stack commands: push a value, pop into a register, pop and discard, call (push a return address and jump) and return (pop an address into the program counter). The block updates the pointer, issues the word request to a synchronous single-port memory, and returns popped values or new program-counter values two cycles after the command. A push or call that would go below the stack floor, or a pop-type command that finds the stack empty, is refused: the pointer holds, no memory request is made, and a sticky fault flag rises.

Top module: `stack_guard_unit`

## Requirements
- R1: After reset the pointer reads 0, both fault flags are low, and no memory request, popped-value strobe or program-counter strobe is asserted.
- R2: A header commit (ld_field 3) sets the pointer, visible the cycle after, to the sum of the last written heap size (ld_field 0), stack size (ld_field 1) and program length (ld_field 2).
- R3: A push (cmd_op 0) decrements the pointer and, the cycle after the command, issues a write of cmd_data at the decremented address.
- R4: A pop into a register (cmd_op 1) issues a read at the current pointer, increments the pointer, and two cycles after the command pulses pop_valid with the word read.
- R5: A discarding pop (cmd_op 2) increments the pointer with no memory request and no pop_valid or pc_valid pulse.
- R6: A call (cmd_op 3) writes cmd_data as the return address at the decremented pointer and, two cycles after the command, pulses pc_valid with cmd_target.
- R7: A return (cmd_op 4) reads at the current pointer, increments it, and two cycles after the command pulses pc_valid with the word read.
- R8: A push or call issued while the pointer is less than or equal to the memory size minus the stack size leaves the pointer unchanged, makes no memory request and no pc_valid pulse, and sets the overflow flag.
- R9: A pop, discarding pop or return issued while the pointer equals the memory size leaves the pointer unchanged, makes no memory request and no output pulse, and sets the underflow flag.
- R10: Once set, a fault flag stays high through further commands and header commits until reset.
- R11: Command codes 5, 6 and 7 have no effect: pointer, memory port and outputs stay idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid | input | 1 | Header word or commit strobe |
| ld_field | input | 2 | 0 heap size, 1 stack size, 2 program length, 3 commit |
| ld_data | input | W | Header word value |
| cmd_valid | input | 1 | Stack command strobe |
| cmd_op | input | 3 | 0 push, 1 pop, 2 discard, 3 call, 4 return |
| cmd_data | input | W | Value to push or return address for a call |
| cmd_target | input | W | Jump target for a call |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Write enable for the request |
| mem_addr | output | W | Word address of the request |
| mem_wdata | output | W | Write data |
| mem_rdata | input | W | Read data, one cycle after the request |
| pop_valid | output | 1 | Popped value available |
| pop_data | output | W | Popped value |
| pc_valid | output | 1 | New program counter available |
| pc_value | output | W | New program counter |
| sp_out | output | W | Current stack pointer |
| ovf_fault | output | 1 | Sticky stack overflow flag |
| unf_fault | output | 1 | Sticky stack underflow flag |

## Verification
The bench pushes until the pointer reaches the floor exactly, so a guard that compares with the wrong strictness either refuses the last legal push or writes one word into the heap. It pops back to the top and once more, where a design that tests for underflow after the increment would read past the end of memory and run the pointer beyond the memory size. It interleaves call and return so that a mixed-up result path would show as the return address landing in pop_data or the target arriving a cycle early, and it commits a new header after faults to catch flags that clear on reload instead of only on reset. A discarding pop is watched on the memory port, where a design that reads anyway would show a stray request.

// File: rtl/stack_guard_pkg.sv
package stack_guard_pkg;
  typedef enum logic [2:0] {
    SOP_PUSH = 3'd0,
    SOP_POP  = 3'd1,
    SOP_DROP = 3'd2,
    SOP_CALL = 3'd3,
    SOP_RET  = 3'd4
  } sop_e;

  typedef enum logic [1:0] {
    HF_HEAP   = 2'd0,
    HF_STACK  = 2'd1,
    HF_PROG   = 2'd2,
    HF_COMMIT = 2'd3
  } hfield_e;

  typedef enum logic [1:0] {
    RK_NONE  = 2'd0,
    RK_VALUE = 2'd1,
    RK_RET   = 2'd2,
    RK_CALL  = 2'd3
  } rkind_e;
endpackage

// File: rtl/sg_header.sv
module sg_header
  import stack_guard_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld_valid,
  input  logic [1:0]   ld_field,
  input  logic [W-1:0] ld_data,
  output logic         commit,
  output logic [W-1:0] size_next,
  output logic [W-1:0] size_q,
  output logic [W-1:0] floor_q
);
  logic [W-1:0] heap_q, stack_q, prog_q;
  logic [W-1:0] floor_next;

  assign commit     = ld_valid && (ld_field == HF_COMMIT);
  assign floor_next = prog_q + heap_q;
  assign size_next  = floor_next + stack_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      heap_q  <= '0;
      stack_q <= '0;
      prog_q  <= '0;
      size_q  <= '0;
      floor_q <= '0;
    end else if (ld_valid) begin
      case (hfield_e'(ld_field))
        HF_HEAP:  heap_q  <= ld_data;
        HF_STACK: stack_q <= ld_data;
        HF_PROG:  prog_q  <= ld_data;
        default: begin
          size_q  <= size_next;
          floor_q <= floor_next;
        end
      endcase
    end
  end

  // The floor never lies above the top of memory.
  AST_FLOOR_BELOW_TOP: assert property (@(posedge clk) disable iff (rst)
    floor_q <= size_q); // R2
endmodule

// File: rtl/sg_check.sv
module sg_check
  import stack_guard_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         cmd_valid,
  input  logic [2:0]   cmd_op,
  input  logic         commit,
  input  logic [W-1:0] sp_q,
  input  logic [W-1:0] size_q,
  input  logic [W-1:0] floor_q,
  output logic         go_grow,
  output logic         go_shrink,
  output logic         ovf_hit,
  output logic         unf_hit
);
  logic live, is_grow, is_shrink, room, filled;

  always_comb begin
    live      = cmd_valid && !commit;
    is_grow   = (cmd_op == SOP_PUSH) || (cmd_op == SOP_CALL);
    is_shrink = (cmd_op == SOP_POP) || (cmd_op == SOP_DROP) || (cmd_op == SOP_RET);
    room      = sp_q > floor_q;
    filled    = sp_q < size_q;
    go_grow   = live && is_grow && room;
    go_shrink = live && is_shrink && filled;
    ovf_hit   = live && is_grow && !room;
    unf_hit   = live && is_shrink && !filled;
  end
endmodule

// File: rtl/sg_pointer.sv
module sg_pointer
  import stack_guard_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         commit,
  input  logic [W-1:0] size_next,
  input  logic [W-1:0] size_q,
  input  logic [W-1:0] floor_q,
  input  logic         go_grow,
  input  logic         go_shrink,
  input  logic         ovf_hit,
  input  logic         unf_hit,
  input  logic [2:0]   cmd_op,
  input  logic [W-1:0] cmd_data,
  output logic [W-1:0] sp_q,
  output logic         mem_req,
  output logic         mem_we,
  output logic [W-1:0] mem_addr,
  output logic [W-1:0] mem_wdata,
  output logic         ovf_q,
  output logic         unf_q
);
  localparam logic [W-1:0] ONE = W'(1);
  logic is_drop;

  assign is_drop = (cmd_op == SOP_DROP);

  always_ff @(posedge clk) begin
    if (rst) begin
      sp_q      <= '0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      ovf_q     <= 1'b0;
      unf_q     <= 1'b0;
    end else begin
      mem_req   <= go_grow || (go_shrink && !is_drop);
      mem_we    <= go_grow;
      mem_addr  <= go_grow ? (sp_q - ONE) : sp_q;
      mem_wdata <= cmd_data;
      if (ovf_hit) ovf_q <= 1'b1;
      if (unf_hit) unf_q <= 1'b1;
      if (commit)         sp_q <= size_next;
      else if (go_grow)   sp_q <= sp_q - ONE;
      else if (go_shrink) sp_q <= sp_q + ONE;
    end
  end

  AST_PUSH_STEP: assert property (@(posedge clk) disable iff (rst)
    go_grow |=> (sp_q == $past(sp_q) - ONE)); // R3
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> (mem_addr >= floor_q)); // R8
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_we) |-> (mem_addr < size_q)); // R9
  AST_FAULT_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (ovf_hit || unf_hit) |=> $stable(sp_q)); // R8
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    ovf_q |=> ovf_q); // R10
  AST_UNF_STICKY: assert property (@(posedge clk) disable iff (rst)
    unf_q |=> unf_q); // R10
  AST_SP_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    sp_q <= size_q); // R9
endmodule

// File: rtl/sg_readback.sv
module sg_readback
  import stack_guard_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         go_grow,
  input  logic         go_shrink,
  input  logic [2:0]   cmd_op,
  input  logic [W-1:0] cmd_target,
  input  logic [W-1:0] mem_rdata,
  output logic         pop_valid,
  output logic [W-1:0] pop_data,
  output logic         pc_valid,
  output logic [W-1:0] pc_value
);
  rkind_e       new_kind, s1_kind, s2_kind;
  logic [W-1:0] s1_tgt, s2_tgt;

  always_comb begin
    new_kind = RK_NONE;
    if (go_grow && cmd_op == SOP_CALL)       new_kind = RK_CALL;
    else if (go_shrink && cmd_op == SOP_POP) new_kind = RK_VALUE;
    else if (go_shrink && cmd_op == SOP_RET) new_kind = RK_RET;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_kind   <= RK_NONE;
      s2_kind   <= RK_NONE;
      s1_tgt    <= '0;
      s2_tgt    <= '0;
      pop_valid <= 1'b0;
      pop_data  <= '0;
      pc_valid  <= 1'b0;
      pc_value  <= '0;
    end else begin
      s1_kind   <= new_kind;
      s1_tgt    <= cmd_target;
      s2_kind   <= s1_kind;
      s2_tgt    <= s1_tgt;
      pop_valid <= (s2_kind == RK_VALUE);
      pop_data  <= mem_rdata;
      pc_valid  <= (s2_kind == RK_RET) || (s2_kind == RK_CALL);
      pc_value  <= (s2_kind == RK_CALL) ? s2_tgt : mem_rdata;
    end
  end

  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (rst)
    !(pop_valid && pc_valid)); // R4
endmodule

// File: rtl/stack_guard_unit.sv
module stack_guard_unit
  import stack_guard_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld_valid,
  input  logic [1:0]   ld_field,
  input  logic [W-1:0] ld_data,
  input  logic         cmd_valid,
  input  logic [2:0]   cmd_op,
  input  logic [W-1:0] cmd_data,
  input  logic [W-1:0] cmd_target,
  output logic         mem_req,
  output logic         mem_we,
  output logic [W-1:0] mem_addr,
  output logic [W-1:0] mem_wdata,
  input  logic [W-1:0] mem_rdata,
  output logic         pop_valid,
  output logic [W-1:0] pop_data,
  output logic         pc_valid,
  output logic [W-1:0] pc_value,
  output logic [W-1:0] sp_out,
  output logic         ovf_fault,
  output logic         unf_fault
);
  logic         commit;
  logic [W-1:0] size_next, size_q, floor_q, sp_q;
  logic         go_grow, go_shrink, ovf_hit, unf_hit;

  sg_header #(.W(W)) u_header (
    .clk(clk), .rst(rst), .ld_valid(ld_valid), .ld_field(ld_field),
    .ld_data(ld_data), .commit(commit), .size_next(size_next),
    .size_q(size_q), .floor_q(floor_q)
  );

  sg_check #(.W(W)) u_check (
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .commit(commit), .sp_q(sp_q),
    .size_q(size_q), .floor_q(floor_q), .go_grow(go_grow),
    .go_shrink(go_shrink), .ovf_hit(ovf_hit), .unf_hit(unf_hit)
  );

  sg_pointer #(.W(W)) u_pointer (
    .clk(clk), .rst(rst), .commit(commit), .size_next(size_next),
    .size_q(size_q), .floor_q(floor_q), .go_grow(go_grow),
    .go_shrink(go_shrink), .ovf_hit(ovf_hit), .unf_hit(unf_hit),
    .cmd_op(cmd_op), .cmd_data(cmd_data), .sp_q(sp_q), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .ovf_q(ovf_fault), .unf_q(unf_fault)
  );

  sg_readback #(.W(W)) u_readback (
    .clk(clk), .rst(rst), .go_grow(go_grow), .go_shrink(go_shrink),
    .cmd_op(cmd_op), .cmd_target(cmd_target), .mem_rdata(mem_rdata),
    .pop_valid(pop_valid), .pop_data(pop_data), .pc_valid(pc_valid),
    .pc_value(pc_value)
  );

  assign sp_out = sp_q;
endmodule

// File: tb/stack_guard_unit_test.sv
`timescale 1ns/1ps
module stack_guard_unit_test;
  localparam int W = 16;

  typedef struct packed {
    logic [2:0]   op;
    logic [W-1:0] data;
    logic [W-1:0] tgt;
    logic [W-1:0] sp;
    logic         req;
    logic         we;
    logic [W-1:0] addr;
    logic [W-1:0] wd;
    logic         pop;
    logic         pc;
    logic [W-1:0] val;
    logic         ovf;
    logic         unf;
    logic [3:0]   rq;
  } vec_t;

  // Header 4/3/5: memory size 12, floor 9, pointer starts at 12.
  localparam vec_t TABLE [8] = '{
    '{3'd0, 16'hAAAA, 16'h0000, 16'd11, 1'b1, 1'b1, 16'd11, 16'hAAAA, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 4'd3},  // R3
    '{3'd0, 16'hBBBB, 16'h0000, 16'd10, 1'b1, 1'b1, 16'd10, 16'hBBBB, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 4'd3},  // R3
    '{3'd1, 16'h0000, 16'h0000, 16'd11, 1'b1, 1'b0, 16'd10, 16'h0000, 1'b1, 1'b0, 16'hBBBB, 1'b0, 1'b0, 4'd4},  // R4
    '{3'd3, 16'h0042, 16'h0100, 16'd10, 1'b1, 1'b1, 16'd10, 16'h0042, 1'b0, 1'b1, 16'h0100, 1'b0, 1'b0, 4'd6},  // R6
    '{3'd4, 16'h0000, 16'h0000, 16'd11, 1'b1, 1'b0, 16'd10, 16'h0000, 1'b0, 1'b1, 16'h0042, 1'b0, 1'b0, 4'd7},  // R7
    '{3'd2, 16'h0000, 16'h0000, 16'd12, 1'b0, 1'b0, 16'd0,  16'h0000, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 4'd5},  // R5
    '{3'd5, 16'h1234, 16'h0300, 16'd12, 1'b0, 1'b0, 16'd0,  16'h0000, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 4'd11}, // R11
    '{3'd7, 16'h5678, 16'h0400, 16'd12, 1'b0, 1'b0, 16'd0,  16'h0000, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 4'd11}  // R11
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         ld_valid = 1'b0;
  logic [1:0]   ld_field = '0;
  logic [W-1:0] ld_data = '0;
  logic         cmd_valid = 1'b0;
  logic [2:0]   cmd_op = '0;
  logic [W-1:0] cmd_data = '0;
  logic [W-1:0] cmd_target = '0;
  logic         mem_req, mem_we;
  logic [W-1:0] mem_addr, mem_wdata;
  logic [W-1:0] mem_rdata = '0;
  logic         pop_valid, pc_valid;
  logic [W-1:0] pop_data, pc_value, sp_out;
  logic         ovf_fault, unf_fault;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [W-1:0] mem [64];

  always #2 clk = ~clk;

  stack_guard_unit #(.W(W)) uut (
    .clk(clk), .rst(rst), .ld_valid(ld_valid), .ld_field(ld_field),
    .ld_data(ld_data), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .cmd_target(cmd_target), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .pop_valid(pop_valid), .pop_data(pop_data),
    .pc_valid(pc_valid), .pc_value(pc_value), .sp_out(sp_out),
    .ovf_fault(ovf_fault), .unf_fault(unf_fault)
  );

  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) mem[mem_addr[5:0]] <= mem_wdata;
      mem_rdata <= mem[mem_addr[5:0]];
    end
  end

  task automatic chk(input string rq, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic load_hdr(input logic [W-1:0] heap, input logic [W-1:0] stk,
                          input logic [W-1:0] prog);
    @(negedge clk); ld_valid = 1'b1; ld_field = 2'd0; ld_data = heap;
    @(negedge clk); ld_field = 2'd1; ld_data = stk;
    @(negedge clk); ld_field = 2'd2; ld_data = prog;
    @(negedge clk); ld_field = 2'd3;
    @(negedge clk); ld_valid = 1'b0;
  endtask

  task automatic run_vec(input vec_t v);
    string rq;
    rq = $sformatf("R%0d", v.rq);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = v.op; cmd_data = v.data; cmd_target = v.tgt;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(rq, "sp", sp_out, v.sp);
    chk(rq, "mem_req", W'(mem_req), W'(v.req));
    if (v.req) begin
      chk(rq, "mem_we", W'(mem_we), W'(v.we));
      chk(rq, "mem_addr", mem_addr, v.addr);
      if (v.we) chk(rq, "mem_wdata", mem_wdata, v.wd);
    end
    chk(rq, "ovf", W'(ovf_fault), W'(v.ovf));
    chk(rq, "unf", W'(unf_fault), W'(v.unf));
    @(negedge clk);
    @(negedge clk);
    chk(rq, "pop_valid", W'(pop_valid), W'(v.pop));
    if (v.pop) chk(rq, "pop_data", pop_data, v.val);
    chk(rq, "pc_valid", W'(pc_valid), W'(v.pc));
    if (v.pc) chk(rq, "pc_value", pc_value, v.val);
  endtask

  task automatic reset_check;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: idle reset state
    chk("R1", "sp", sp_out, '0);
    chk("R1", "ovf", W'(ovf_fault), '0);
    chk("R1", "unf", W'(unf_fault), '0);
    chk("R1", "mem_req", W'(mem_req), '0);
    chk("R1", "pop_valid", W'(pop_valid), '0);
    chk("R1", "pc_valid", W'(pc_valid), '0);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    reset_check();
    load_hdr(16'd4, 16'd3, 16'd5);
    chk("R2", "sp after commit", sp_out, 16'd12);

    for (int i = 0; i < 8; i++) run_vec(TABLE[i]);

    // Fill to the floor (R3), then refuse (R8).
    run_vec(vec_t'{3'd0, 16'h1111, 16'h0, 16'd11, 1'b1, 1'b1, 16'd11, 16'h1111, 1'b0, 1'b0, 16'h0, 1'b0, 1'b0, 4'd3});
    run_vec(vec_t'{3'd0, 16'h2222, 16'h0, 16'd10, 1'b1, 1'b1, 16'd10, 16'h2222, 1'b0, 1'b0, 16'h0, 1'b0, 1'b0, 4'd3});
    run_vec(vec_t'{3'd0, 16'h3333, 16'h0, 16'd9,  1'b1, 1'b1, 16'd9,  16'h3333, 1'b0, 1'b0, 16'h0, 1'b0, 1'b0, 4'd8});
    run_vec(vec_t'{3'd0, 16'h4444, 16'h0, 16'd9,  1'b0, 1'b0, 16'd0,  16'h0,    1'b0, 1'b0, 16'h0, 1'b1, 1'b0, 4'd8});
    run_vec(vec_t'{3'd3, 16'h5555, 16'h0200, 16'd9, 1'b0, 1'b0, 16'd0, 16'h0,  1'b0, 1'b0, 16'h0, 1'b1, 1'b0, 4'd8});
    // Drain while overflow stays set (R10, R4, R7).
    run_vec(vec_t'{3'd1, 16'h0, 16'h0, 16'd10, 1'b1, 1'b0, 16'd9,  16'h0, 1'b1, 1'b0, 16'h3333, 1'b1, 1'b0, 4'd10});
    run_vec(vec_t'{3'd1, 16'h0, 16'h0, 16'd11, 1'b1, 1'b0, 16'd10, 16'h0, 1'b1, 1'b0, 16'h2222, 1'b1, 1'b0, 4'd4});
    run_vec(vec_t'{3'd4, 16'h0, 16'h0, 16'd12, 1'b1, 1'b0, 16'd11, 16'h0, 1'b0, 1'b1, 16'h1111, 1'b1, 1'b0, 4'd7});
    // Empty stack (R9).
    run_vec(vec_t'{3'd1, 16'h0, 16'h0, 16'd12, 1'b0, 1'b0, 16'd0, 16'h0, 1'b0, 1'b0, 16'h0, 1'b1, 1'b1, 4'd9});
    run_vec(vec_t'{3'd2, 16'h0, 16'h0, 16'd12, 1'b0, 1'b0, 16'd0, 16'h0, 1'b0, 1'b0, 16'h0, 1'b1, 1'b1, 4'd9});
    run_vec(vec_t'{3'd4, 16'h0, 16'h0, 16'd12, 1'b0, 1'b0, 16'd0, 16'h0, 1'b0, 1'b0, 16'h0, 1'b1, 1'b1, 4'd9});

    // R10: a new commit keeps the faults.
    load_hdr(16'd4, 16'd3, 16'd5);
    chk("R10", "ovf after commit", W'(ovf_fault), W'(1));
    chk("R10", "unf after commit", W'(unf_fault), W'(1));
    chk("R2", "sp after recommit", sp_out, 16'd12);

    // R10/R1: reset clears them.
    reset_check();

    // One-word stack: exactly one push fits (R2, R8 boundary).
    load_hdr(16'd2, 16'd1, 16'd1);
    chk("R2", "sp small header", sp_out, 16'd4);
    run_vec(vec_t'{3'd0, 16'h7777, 16'h0, 16'd3, 1'b1, 1'b1, 16'd3, 16'h7777, 1'b0, 1'b0, 16'h0, 1'b0, 1'b0, 4'd8});
    run_vec(vec_t'{3'd0, 16'h8888, 16'h0, 16'd3, 1'b0, 1'b0, 16'd0, 16'h0,    1'b0, 1'b0, 16'h0, 1'b1, 1'b0, 4'd8});

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule